// File: doc/BRIEF.md
# Address Translation Fault Checker

This block judges one virtual-address translation request in a single combinational pass. It receives the virtual address, the kind of access, the segment descriptor word with its segment base, the page descriptor word (used only when the segment is paged) and the length limit of the section the address falls in. From these it produces either a pass with the physical address, or exactly one fault code. When more than one fault condition holds, a fixed priority decides which code is reported.

On a pass it also raises requests to set the referenced and modified bits of the governing descriptor. A fault-check enable lets the caller probe a translation without side effects. While it is low, the access-permission, write-protect and object-trap checks are skipped and no update is requested. The structural checks on length, validity, presence and offset still apply. A translation enable of zero turns the block into an identity map.

Virtual address layout with the default parameters: bits 31:30 select the section and take no part here. Bits 29:17 are the segment number and bits 16:0 are the segment offset. For a paged segment the offset divides into a page select (16:11) and an in-page offset (10:0).

Top module: `xl_fault_chk`

## Requirements
- R1: With `xlate_en` low the block reports a pass with `pa` equal to `va`, fault code 0 and no update request, whatever the other inputs are.
- R2: A segment number strictly greater than `sec_len` gives fault 1 even with `chk_en` low; equality is not a fault.
- R3: Descriptor bit 2 (valid) clear gives fault 2. Otherwise bit 3 (present) clear gives fault 3 when bit 4 (contiguous) is set, and fault 4 when it is clear (paged).
- R4: For a paged segment the limit is (descriptor bits 21:8 + 1) × 8 bytes. Page select × 4 at or above this limit gives fault 5.
- R5: With `chk_en` high, descriptor bits 1:0 grant access as follows. Code 0 grants nothing. Code 1 grants only access codes 0 (fetch after discontinuity) and 1 (fetch). Code 2 adds codes 2 (address fetch), 3 (operand fetch) and 4 (move translated). Code 3 grants all codes. A denied access gives fault 6.
- R6: A segment offset at or above the limit gives fault 7: always for a contiguous segment, and for a paged segment only when page descriptor bit 4 (last) is set.
- R7: For a paged segment, page descriptor bit 0 (present) clear gives fault 8 even with `chk_en` low.
- R8: With `chk_en` high, access code 5 (write) or 6 (interlocked read) to a page whose bit 3 (write fault) is set gives fault 9.
- R9: With `chk_en` high, a contiguous segment whose descriptor bit 5 (trap) is set gives fault 10, after every other contiguous check has passed.
- R10: Priority from highest to lowest is 1, 2, 3/4, then for paged segments 5, 6, 7, 8, 9, and for contiguous segments 6, 7, 10.
- R11: On a pass, a contiguous segment gives `pa` = `seg_base` + segment offset. A paged segment gives `pa` = page descriptor bits 31:11 followed by `va` bits 10:0.
- R12: On a pass with `chk_en` high, `upd_ref` is set when the governing descriptor's referenced bit is clear. `upd_mod` is set when the access is code 5 or 6 and its modified bit is clear. The segment descriptor uses bits 6 and 7 for these; the page descriptor uses bits 2 and 1. Both requests are 0 with `chk_en` low.
- R13: Exactly one of `ok` and a nonzero `fault_code` holds. When a fault is reported, `pa`, `upd_ref` and `upd_mod` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xlate_en | input | 1 | Translation on; low gives the identity map |
| chk_en | input | 1 | Enable permission, write-protect and trap checks and update requests |
| va | input | ADDR_W | Virtual address |
| acc | input | 4 | Access-kind code |
| sd_word | input | ADDR_W | Segment descriptor flags, permission and length |
| seg_base | input | ADDR_W | Segment base / page table address from the descriptor pair |
| pd_word | input | ADDR_W | Page descriptor (paged segments only) |
| sec_len | input | SSL_W | Highest segment number allowed in the section |
| ok | output | 1 | Translation passes |
| fault_code | output | 4 | Fault kind, 0 when none |
| pa | output | ADDR_W | Physical address, 0 on a fault |
| upd_ref | output | 1 | Request to set the referenced bit |
| upd_mod | output | 1 | Request to set the modified bit |

## Verification
The closest collisions are between a fault and the update requests that a pass would raise, for example a write to a write-protected page whose modified bit is clear, or a trapped contiguous segment whose referenced bit is clear. Directed vectors set both conditions at once. The bench expects the fault code with both requests at zero, then flips `chk_en` low to see the fault vanish and the requests stay at zero. Length, offset and trap faults are also stacked in one vector, and the bench confirms that the higher-ranked code wins. A behavioural model compares thousands of biased random vectors on every clock.

// File: rtl/xl_pkg.sv
package xl_pkg;

   localparam int ACC_W = 4;

   // access-kind codes
   localparam logic [ACC_W-1:0] A_FETCH_DISC = 4'd0;
   localparam logic [ACC_W-1:0] A_FETCH      = 4'd1;
   localparam logic [ACC_W-1:0] A_ADDR       = 4'd2;
   localparam logic [ACC_W-1:0] A_OPND       = 4'd3;
   localparam logic [ACC_W-1:0] A_MOVX       = 4'd4;
   localparam logic [ACC_W-1:0] A_WRITE      = 4'd5;
   localparam logic [ACC_W-1:0] A_ILOCK      = 4'd6;

   // segment descriptor bit positions
   localparam int SD_PERM_LO = 0;
   localparam int SD_VALID   = 2;
   localparam int SD_PRES    = 3;
   localparam int SD_CONTIG  = 4;
   localparam int SD_TRAP    = 5;
   localparam int SD_REF     = 6;
   localparam int SD_MOD     = 7;
   localparam int SD_LEN_LO  = 8;

   // page descriptor bit positions
   localparam int PD_PRES = 0;
   localparam int PD_MOD  = 1;
   localparam int PD_REF  = 2;
   localparam int PD_WFLT = 3;
   localparam int PD_LAST = 4;
   localparam int PD_HI_FLAG = 4;

   typedef enum logic [3:0] {
      F_NONE        = 4'd0,
      F_SECT_LEN    = 4'd1,
      F_SD_BAD      = 4'd2,
      F_SEG_ABSENT  = 4'd3,
      F_PTAB_ABSENT = 4'd4,
      F_PTAB_LEN    = 4'd5,
      F_ACCESS      = 4'd6,
      F_SEG_OFF     = 4'd7,
      F_PAGE_ABSENT = 4'd8,
      F_WPROT       = 4'd9,
      F_OBJ_TRAP    = 4'd10
   } fault_e;

   typedef struct packed {
      logic sec_over;
      logic sd_bad;
      logic sd_absent;
      logic paged;
      logic pdt_over;
      logic perm_deny;
      logic off_over;
      logic pg_absent;
      logic wprot;
      logic trap;
   } cond_t;

   function automatic logic exec_ok(input int code);
      return (code == int'(A_FETCH_DISC)) || (code == int'(A_FETCH));
   endfunction

   function automatic logic rdx_ok(input int code);
      return exec_ok(code) || (code == int'(A_ADDR)) ||
             (code == int'(A_OPND)) || (code == int'(A_MOVX));
   endfunction

   function automatic logic is_write(input logic [ACC_W-1:0] code);
      return (code == A_WRITE) || (code == A_ILOCK);
   endfunction

endpackage

// File: rtl/xl_perm.sv
module xl_perm
   import xl_pkg::*;
#(
   parameter int CODE_W = ACC_W
) (
   input  logic [1:0]        perm,
   input  logic [CODE_W-1:0] acc,
   output logic              allow
);
   localparam int NCODE = 1 << CODE_W;

   if (CODE_W < 3) begin : g_bad_width
      $error("xl_perm: CODE_W too narrow for the access codes");
   end

   logic [NCODE-1:0] exec_set;
   logic [NCODE-1:0] rdx_set;

   for (genvar c = 0; c < NCODE; c++) begin : g_code
      assign exec_set[c] = exec_ok(c);
      assign rdx_set[c]  = rdx_ok(c);
   end

   always_comb begin
      unique case (perm)
         2'd0:    allow = 1'b0;
         2'd1:    allow = exec_set[acc];
         2'd2:    allow = rdx_set[acc];
         default: allow = 1'b1;
      endcase
   end
endmodule

// File: rtl/xl_limits.sv
module xl_limits #(
   parameter int SSL_W = 13,
   parameter int PSL_W = 6,
   parameter int SOT_W = 17,
   parameter int LEN_W = 14
) (
   input  logic [SSL_W-1:0] ssl,
   input  logic [SSL_W-1:0] sec_len,
   input  logic [PSL_W-1:0] psl,
   input  logic [SOT_W-1:0] sot,
   input  logic [LEN_W-1:0] len,
   output logic             sec_over,
   output logic             pdt_over,
   output logic             off_over
);
   localparam int MW = LEN_W + 4;

   if (MW < PSL_W + 2 || MW < SOT_W) begin : g_bad_width
      $error("xl_limits: limit width cannot hold the compared offsets");
   end

   logic [MW-1:0] lim;

   // byte limit = (len + 1) * 8
   assign lim      = MW'({len, 3'b000}) + MW'(8);
   assign sec_over = ssl > sec_len;
   assign pdt_over = MW'({psl, 2'b00}) >= lim;
   assign off_over = MW'(sot) >= lim;
endmodule

// File: rtl/xl_prio.sv
module xl_prio
   import xl_pkg::*;
(
   input  cond_t  cnd,
   input  logic   chk_en,
   output fault_e fault
);
   always_comb begin
      fault = F_NONE;
      if (cnd.sec_over)
         fault = F_SECT_LEN;
      else if (cnd.sd_bad)
         fault = F_SD_BAD;
      else if (cnd.sd_absent)
         fault = cnd.paged ? F_PTAB_ABSENT : F_SEG_ABSENT;
      else if (cnd.paged) begin
         if (cnd.pdt_over)
            fault = F_PTAB_LEN;
         else if (chk_en && cnd.perm_deny)
            fault = F_ACCESS;
         else if (cnd.off_over)
            fault = F_SEG_OFF;
         else if (cnd.pg_absent)
            fault = F_PAGE_ABSENT;
         else if (chk_en && cnd.wprot)
            fault = F_WPROT;
      end else begin
         if (chk_en && cnd.perm_deny)
            fault = F_ACCESS;
         else if (cnd.off_over)
            fault = F_SEG_OFF;
         else if (chk_en && cnd.trap)
            fault = F_OBJ_TRAP;
      end
   end
endmodule

// File: rtl/xl_fault_chk.sv
module xl_fault_chk
   import xl_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int SEC_W      = 2,
   parameter int SSL_W      = 13,
   parameter int PG_OFF_W   = 11,
   parameter bit CONTIG_ADD = 1'b1
) (
   input  logic              xlate_en,
   input  logic              chk_en,
   input  logic [ADDR_W-1:0] va,
   input  logic [ACC_W-1:0]  acc,
   input  logic [ADDR_W-1:0] sd_word,
   input  logic [ADDR_W-1:0] seg_base,
   input  logic [ADDR_W-1:0] pd_word,
   input  logic [SSL_W-1:0]  sec_len,
   output logic              ok,
   output logic [3:0]        fault_code,
   output logic [ADDR_W-1:0] pa,
   output logic              upd_ref,
   output logic              upd_mod
);
   localparam int SOT_W = ADDR_W - SEC_W - SSL_W;
   localparam int PSL_W = SOT_W - PG_OFF_W;
   localparam int LEN_W = SOT_W - 3;

   if (SOT_W <= PG_OFF_W || PG_OFF_W <= PD_HI_FLAG + 1) begin : g_bad_split
      $error("xl_fault_chk: address split leaves no page select or flag room");
   end
   if (SD_LEN_LO + LEN_W >= ADDR_W) begin : g_bad_sd
      $error("xl_fault_chk: descriptor length field does not fit");
   end

   logic [SSL_W-1:0]  ssl;
   logic [SOT_W-1:0]  sot;
   logic [PSL_W-1:0]  psl;
   logic [LEN_W-1:0]  len;
   logic              paged;
   logic              allow;
   logic              sec_over, pdt_over, off_over;
   cond_t             cnd;
   fault_e            fault;
   logic [ADDR_W-1:0] contig_pa, paged_pa;
   logic              ref_bit, mod_bit;
   logic              unused_bits;

   assign ssl   = va[SOT_W +: SSL_W];
   assign sot   = va[SOT_W-1:0];
   assign psl   = va[PG_OFF_W +: PSL_W];
   assign len   = sd_word[SD_LEN_LO +: LEN_W];
   assign paged = ~sd_word[SD_CONTIG];
   assign unused_bits = ^{va[ADDR_W-1 -: SEC_W], sd_word[ADDR_W-1:SD_LEN_LO+LEN_W],
                          pd_word[PG_OFF_W-1:PD_HI_FLAG+1]};

   xl_perm #(.CODE_W(ACC_W)) u_perm (
      .perm  (sd_word[SD_PERM_LO +: 2]),
      .acc   (acc),
      .allow (allow)
   );

   xl_limits #(.SSL_W(SSL_W), .PSL_W(PSL_W), .SOT_W(SOT_W), .LEN_W(LEN_W)) u_lim (
      .ssl      (ssl),
      .sec_len  (sec_len),
      .psl      (psl),
      .sot      (sot),
      .len      (len),
      .sec_over (sec_over),
      .pdt_over (pdt_over),
      .off_over (off_over)
   );

   always_comb begin
      cnd.sec_over  = sec_over;
      cnd.sd_bad    = ~sd_word[SD_VALID];
      cnd.sd_absent = ~sd_word[SD_PRES];
      cnd.paged     = paged;
      cnd.pdt_over  = pdt_over;
      cnd.perm_deny = ~allow;
      cnd.off_over  = off_over & (~paged | pd_word[PD_LAST]);
      cnd.pg_absent = ~pd_word[PD_PRES];
      cnd.wprot     = is_write(acc) & pd_word[PD_WFLT];
      cnd.trap      = sd_word[SD_TRAP];
   end

   xl_prio u_prio (
      .cnd    (cnd),
      .chk_en (chk_en),
      .fault  (fault)
   );

   if (CONTIG_ADD) begin : g_base_add
      assign contig_pa = seg_base + ADDR_W'(sot);
   end else begin : g_base_or
      assign contig_pa = seg_base | ADDR_W'(sot);
   end

   assign paged_pa = {pd_word[ADDR_W-1:PG_OFF_W], va[PG_OFF_W-1:0]};
   assign ref_bit  = paged ? pd_word[PD_REF] : sd_word[SD_REF];
   assign mod_bit  = paged ? pd_word[PD_MOD] : sd_word[SD_MOD];

   always_comb begin
      ok         = 1'b0;
      fault_code = 4'd0;
      pa         = '0;
      upd_ref    = 1'b0;
      upd_mod    = 1'b0;
      if (!xlate_en) begin
         ok = 1'b1;
         pa = va;
      end else if (fault != F_NONE) begin
         fault_code = fault;
      end else begin
         ok      = 1'b1;
         pa      = paged ? paged_pa : contig_pa;
         upd_ref = chk_en & ~ref_bit;
         upd_mod = chk_en & is_write(acc) & ~mod_bit;
      end
   end
endmodule

// File: rtl/xl_fault_chk_sva.sv
module xl_fault_chk_sva #(
   parameter int ADDR_W = 32,
   parameter int SSL_W  = 13,
   parameter int SOT_W  = 17
) (
   input logic              xlate_en,
   input logic              chk_en,
   input logic [ADDR_W-1:0] va,
   input logic [3:0]        acc,
   input logic [ADDR_W-1:0] sd_word,
   input logic [ADDR_W-1:0] pd_word,
   input logic [SSL_W-1:0]  sec_len,
   input logic              ok,
   input logic [3:0]        fault_code,
   input logic [ADDR_W-1:0] pa,
   input logic              upd_ref,
   input logic              upd_mod
);
   always_comb begin
      p_single_outcome_r13: assert (ok != (fault_code != 4'd0));
      if (fault_code != 4'd0) begin
         p_fault_quiet_r13: assert (pa == '0 && !upd_ref && !upd_mod);
      end
      if (!xlate_en) begin
         p_bypass_r1: assert (ok && pa == va && !upd_ref && !upd_mod);
      end
      if (xlate_en && va[SOT_W +: SSL_W] > sec_len) begin
         p_sect_len_r2: assert (fault_code == 4'd1);
      end
      if (!chk_en) begin
         p_nochk_r12: assert (fault_code != 4'd6 && fault_code != 4'd9 &&
                              fault_code != 4'd10 && !upd_ref && !upd_mod);
      end
      if (xlate_en && ok && !sd_word[4]) begin
         p_page_present_r7: assert (pd_word[0]);
      end
      if (upd_mod) begin
         p_mod_write_r12: assert (acc == 4'd5 || acc == 4'd6);
      end
   end
endmodule

bind xl_fault_chk xl_fault_chk_sva #(
   .ADDR_W (ADDR_W),
   .SSL_W  (SSL_W),
   .SOT_W  (SOT_W)
) u_sva (
   .xlate_en   (xlate_en),
   .chk_en     (chk_en),
   .va         (va),
   .acc        (acc),
   .sd_word    (sd_word),
   .pd_word    (pd_word),
   .sec_len    (sec_len),
   .ok         (ok),
   .fault_code (fault_code),
   .pa         (pa),
   .upd_ref    (upd_ref),
   .upd_mod    (upd_mod)
);

// File: tb/sim_xl_fault_chk.sv
module sim_xl_fault_chk;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xe, ce;
   logic [31:0] v, sd, base, pd;
   logic [3:0]  a;
   logic [12:0] sl;
   logic        ok, ur, um;
   logic [3:0]  fc;
   logic [31:0] pa;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xl_fault_chk u0 (
      .xlate_en(xe), .chk_en(ce), .va(v), .acc(a), .sd_word(sd),
      .seg_base(base), .pd_word(pd), .sec_len(sl),
      .ok(ok), .fault_code(fc), .pa(pa), .upd_ref(ur), .upd_mod(um)
   );

   function automatic bit [31:0] mk_sd(int perm, bit vl, bit pr, bit cg, bit tr,
                                       bit rf, bit md, int len);
      bit [13:0] l = 14'(len);
      bit [1:0]  p = 2'(perm);
      return {10'd0, l, md, rf, tr, cg, pr, vl, p};
   endfunction

   function automatic bit [31:0] mk_pd(int pbase, bit last, bit wf, bit rf, bit md, bit pr);
      bit [20:0] b = 21'(pbase);
      return {b, 6'd0, last, wf, rf, md, pr};
   endfunction

   function automatic bit [31:0] mk_va(int seg, int off);
      bit [12:0] s = 13'(seg);
      bit [16:0] o = 17'(off);
      return {2'b00, s, o};
   endfunction

   // behavioural reference of the requirements
   task automatic model(input bit mxe, mce, input bit [31:0] mv, input bit [3:0] ma,
                        input bit [31:0] msd, mbase, mpd, input bit [12:0] msl,
                        output bit e_ok, output int e_f, output bit [31:0] e_pa,
                        output bit e_r, output bit e_m);
      int  seg   = int'(mv[29:17]);
      int  off   = int'(mv[16:0]);
      int  pg    = int'(mv[16:11]);
      int  lim   = (int'(msd[21:8]) + 1) * 8;
      bit  paged = !msd[4];
      bit  wr    = (ma == 5) || (ma == 6);
      bit  allow;
      int  f = 0;
      case (msd[1:0])
         2'd0: allow = 0;
         2'd1: allow = (ma <= 1);
         2'd2: allow = (ma <= 4);
         default: allow = 1;
      endcase
      e_ok = 0; e_f = 0; e_pa = 0; e_r = 0; e_m = 0;
      if (!mxe) begin
         e_ok = 1; e_pa = mv;
         return;
      end
      if (seg > int'(msl)) f = 1;
      else if (!msd[2]) f = 2;
      else if (!msd[3]) f = paged ? 4 : 3;
      else if (paged) begin
         if (pg * 4 >= lim) f = 5;
         else if (mce && !allow) f = 6;
         else if (mpd[4] && off >= lim) f = 7;
         else if (!mpd[0]) f = 8;
         else if (mce && wr && mpd[3]) f = 9;
      end else begin
         if (mce && !allow) f = 6;
         else if (off >= lim) f = 7;
         else if (mce && msd[5]) f = 10;
      end
      e_f = f;
      if (f != 0) return;
      e_ok = 1;
      if (paged) begin
         e_pa = {mpd[31:11], mv[10:0]};
         e_r  = mce && !mpd[2];
         e_m  = mce && wr && !mpd[1];
      end else begin
         e_pa = mbase + 32'(off);
         e_r  = mce && !msd[6];
         e_m  = mce && wr && !msd[7];
      end
   endtask

   function automatic string tag_of(int f);
      case (f)
         0: return "R11";
         1: return "R2";
         2, 3, 4: return "R3";
         5: return "R4";
         6: return "R5";
         7: return "R6";
         8: return "R7";
         9: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic run(string tag, bit txe, tce, bit [31:0] tv, bit [3:0] ta,
                      bit [31:0] tsd, tbase, tpd, bit [12:0] tsl, int hand_f);
      bit e_ok, e_r, e_m;
      int e_f;
      bit [31:0] e_pa;
      model(txe, tce, tv, ta, tsd, tbase, tpd, tsl, e_ok, e_f, e_pa, e_r, e_m);
      if (hand_f >= 0) e_f = hand_f;
      @(posedge clk);
      #1;
      xe = txe; ce = tce; v = tv; a = ta; sd = tsd; base = tbase; pd = tpd; sl = tsl;
      @(negedge clk);
      n_cmp++;
      if (ok !== e_ok || int'(fc) != e_f || pa !== e_pa || ur !== e_r || um !== e_m) begin
         n_bad++;
         $display("FAIL %s: actual ok=%0b f=%0d pa=%08h r=%0b m=%0b expected ok=%0b f=%0d pa=%08h r=%0b m=%0b",
                  tag, ok, fc, pa, ur, um, e_ok, e_f, e_pa, e_r, e_m);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      bit [31:0] gsd;
      xe = 0; ce = 0; v = 0; a = 0; sd = 0; base = 0; pd = 0; sl = 0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // reset/idle state: identity map (R1)
      @(negedge clk);
      n_cmp++;
      if (!ok || fc != 0 || pa != 0 || ur || um) begin
         n_bad++;
         $display("FAIL R1 idle: actual ok=%0b f=%0d expected ok=1 f=0", ok, fc);
      end

      gsd = mk_sd(3, 1, 1, 1, 0, 0, 0, 14'h3FFF);
      // R1 bypass ignores a broken descriptor
      run("R1", 0, 1, 32'h1234_5678, 5, 0, 0, 0, 0, 0);
      // R2 beats an invalid descriptor (R10), even without checks
      run("R2", 1, 0, mk_va(5, 0), 1, 0, 0, 0, 4, 1);
      run("R2 equal", 1, 1, mk_va(4, 12), 1, gsd, 32'h100, 0, 4, 0);
      // R3
      run("R3 invalid", 1, 1, mk_va(0, 0), 1, mk_sd(3, 0, 1, 1, 0, 1, 1, 5), 0, 0, 1, 2);
      run("R3 seg absent", 1, 1, mk_va(0, 0), 1, mk_sd(3, 1, 0, 1, 0, 1, 1, 5), 0, 0, 1, 3);
      run("R3 pdt absent", 1, 0, mk_va(0, 0), 1, mk_sd(3, 1, 0, 0, 0, 1, 1, 5), 0, 0, 1, 4);
      // R4 limit 8 bytes
      run("R4 over", 1, 1, mk_va(0, 2 << 11), 1, mk_sd(3, 1, 1, 0, 0, 1, 1, 0), 0,
          mk_pd(7, 1, 0, 1, 1, 0), 1, 5);
      run("R4 under", 1, 1, mk_va(0, 1 << 11), 1, mk_sd(3, 1, 1, 0, 0, 1, 1, 0), 0,
          mk_pd(7, 0, 0, 1, 1, 1), 1, 0);
      // R5
      run("R5 exec-only addr", 1, 1, mk_va(0, 4), 2, mk_sd(1, 1, 1, 1, 0, 1, 1, 9), 32'h40, 0, 0, 6);
      run("R5 exec-only fetch", 1, 1, mk_va(0, 4), 0, mk_sd(1, 1, 1, 1, 0, 1, 1, 9), 32'h40, 0, 0, 0);
      run("R5 nochk", 1, 0, mk_va(0, 4), 2, mk_sd(1, 1, 1, 1, 0, 1, 1, 9), 32'h40, 0, 0, 0);
      run("R5 rdx move", 1, 1, mk_va(0, 4), 4, mk_sd(2, 1, 1, 1, 0, 1, 1, 9), 32'h40, 0, 0, 0);
      run("R5 rdx write", 1, 1, mk_va(0, 4), 5, mk_sd(2, 1, 1, 1, 0, 1, 1, 9), 32'h40, 0, 0, 6);
      run("R5 none", 1, 1, mk_va(0, 4), 1, mk_sd(0, 1, 1, 1, 0, 1, 1, 9), 32'h40, 0, 0, 6);
      run("R5 all ilock", 1, 1, mk_va(0, 4), 6, mk_sd(3, 1, 1, 1, 0, 1, 1, 9), 32'h40, 0, 0, 0);
      // R6 contiguous limit 16, and trap beneath offset (R10)
      run("R6 contig over", 1, 1, mk_va(0, 16), 1, mk_sd(3, 1, 1, 1, 1, 1, 1, 1), 32'h1000, 0, 0, 7);
      run("R6 contig edge", 1, 1, mk_va(0, 15), 1, mk_sd(3, 1, 1, 1, 0, 1, 1, 1), 32'h1000, 0, 0, 0);
      run("R6 paged last", 1, 1, mk_va(0, 32'h2000), 1, mk_sd(3, 1, 1, 0, 0, 1, 1, 32'h3FF), 0,
          mk_pd(3, 1, 0, 1, 1, 1), 0, 7);
      run("R6 paged notlast", 1, 1, mk_va(0, 32'h2000), 1, mk_sd(3, 1, 1, 0, 0, 1, 1, 32'h3FF), 0,
          mk_pd(3, 0, 0, 1, 1, 1), 0, 0);
      // R7
      run("R7", 1, 0, mk_va(0, 5), 1, mk_sd(3, 1, 1, 0, 0, 1, 1, 32'h3FFF), 0,
          mk_pd(3, 0, 1, 1, 1, 0), 0, 8);
      // R8 with clear modified bit: fault wins over update (R13)
      run("R8 write", 1, 1, mk_va(0, 5), 5, mk_sd(3, 1, 1, 0, 0, 1, 1, 32'h3FFF), 0,
          mk_pd(3, 0, 1, 0, 0, 1), 0, 9);
      run("R8 read", 1, 1, mk_va(0, 5), 3, mk_sd(3, 1, 1, 0, 0, 1, 1, 32'h3FFF), 0,
          mk_pd(3, 0, 1, 1, 1, 1), 0, 0);
      run("R8 nochk", 1, 0, mk_va(0, 5), 6, mk_sd(3, 1, 1, 0, 0, 1, 1, 32'h3FFF), 0,
          mk_pd(3, 0, 1, 0, 0, 1), 0, 0);
      // R9
      run("R9 trap", 1, 1, mk_va(0, 5), 1, mk_sd(3, 1, 1, 1, 1, 0, 0, 32'h3FFF), 32'h8000, 0, 0, 10);
      run("R9 nochk", 1, 0, mk_va(0, 5), 1, mk_sd(3, 1, 1, 1, 1, 0, 0, 32'h3FFF), 32'h8000, 0, 0, 0);
      // R11 paged address composition
      run("R11 paged", 1, 0, mk_va(0, (3 << 11) | 32'h1A5), 1, mk_sd(3, 1, 1, 0, 0, 1, 1, 32'h3FFF), 0,
          mk_pd(32'h0ABCD, 0, 0, 1, 1, 1), 0, 0);
      // R12 update requests
      run("R12 contig both", 1, 1, mk_va(0, 5), 5, mk_sd(3, 1, 1, 1, 0, 0, 0, 32'h3FFF), 32'h300, 0, 0, 0);
      run("R12 contig set", 1, 1, mk_va(0, 5), 5, mk_sd(3, 1, 1, 1, 0, 1, 1, 32'h3FFF), 32'h300, 0, 0, 0);
      run("R12 paged read", 1, 1, mk_va(0, 5), 1, mk_sd(3, 1, 1, 0, 0, 1, 1, 32'h3FFF), 0,
          mk_pd(9, 0, 0, 0, 0, 1), 0, 0);

      // biased random mix, judged by the reference (R10, R13)
      for (int i = 0; i < 3000; i++) begin
         bit [31:0] rv, rsd, rpd, rb;
         bit [12:0] rsl;
         bit [3:0]  ra;
         bit rce;
         int e_f;
         bit e_ok, e_r, e_m;
         bit [31:0] e_pa;
         rv  = $urandom;
         rsd = $urandom;
         rpd = $urandom;
         rb  = $urandom;
         ra  = 4'($urandom % 16);
         rce = 1'($urandom % 2);
         rsl = ($urandom % 4 != 0) ? 13'h1FFF : 13'($urandom);
         if ($urandom % 8 != 0) rsd[3:2] = 2'b11;
         if ($urandom % 8 != 0) rpd[0] = 1'b1;
         model(1, rce, rv, ra, rsd, rb, rpd, rsl, e_ok, e_f, e_pa, e_r, e_m);
         run(tag_of(e_f), 1, rce, rv, ra, rsd, rb, rpd, rsl, -1);
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule